// File: doc/BRIEF.md
# Rotating-Pointer FSK Bit Sequencer

This block serialises a fixed-width data word onto an FSK sample stream. It handles one data bit per symbol period. For each bit it outputs one of two sample words: a "high" tone word when the bit is 1 and a "low" tone word when the bit is 0. It sends the word starting from the least significant bit. When the last bit has been sent, it starts the word again immediately, so the same word repeats without a gap. A one-cycle marker shows where each repetition begins.

The block does not keep a binary bit index. Instead it keeps a one-hot register that rotates one place per symbol. The current bit is found by masking the data word with that register and OR-reducing the result, so no index decoder is needed. A free-running prescaler sets the symbol length. The enable input gates the block. While enable is low, the sample output is zero and the sequencer is parked at the first bit with a fresh symbol period, ready for the next enabled burst.

Top module: `fsksq_top`

## Requirements
- R1: Reset is asynchronous and active low (`rst_ni`). While it is asserted, `sample_o` is 0 and `frame_o` is 0. After release with `en_i` high, bit 0 is sent first and lasts a full symbol period.
- R2: Bits are sent from the least significant bit upward. Symbol k of an enabled run carries `word_i[k]`.
- R3: When the selected bit is 1, `sample_o` equals `tone_hi_i`. When the selected bit is 0, `sample_o` equals `tone_lo_i`.
- R4: Each symbol lasts 2**PRESC_W clock cycles (1024 by default). After the first enabled clock edge E0, `sample_o` shows symbol k from edge E(1024k) through edge E(1024k+1023).
- R5: After bit DATA_W-1 (bit 21 by default), the sequencer returns to bit 0 and the word repeats with no gap.
- R6: `frame_o` is high for exactly one cycle, after edge E(1024*DATA_W-1). That is the last cycle of bit DATA_W-1's symbol, on which the pointer has just returned to bit 0. At all other times `frame_o` is low.
- R7: Sampling `en_i` low at a clock edge makes `sample_o` 0 from that edge on. It also clears the prescaler and parks the pointer at bit 0, so the next enabled run starts at bit 0 with a full symbol.
- R8: The sample output is registered every enabled cycle from the current tone words, data word and pointer. A change on `tone_hi_i`, `tone_lo_i` or `word_i` appears on `sample_o` one clock later.
- R9: The pointer always holds exactly one set bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces zero output and parks the sequencer |
| tone_hi_i | input | TONE_W (8) | Sample word sent for a 1 bit |
| tone_lo_i | input | TONE_W (8) | Sample word sent for a 0 bit |
| word_i | input | DATA_W (22) | Data word to serialise, LSB first |
| sample_o | output | TONE_W (8) | Registered modulated sample |
| frame_o | output | 1 | One-cycle pulse when the pointer wraps to bit 0 |

## Verification
The properties assume that `en_i`, the tone words and the data word are sampled cleanly at rising clock edges. They also assume that reset release does not race a clock edge. The bench therefore changes every input on the falling edge. It applies and removes reset between edges, even when it pulses reset in the middle of a run. The tone-follow property compares the output with the tone words one edge earlier, so the tone words may change at any sampled cycle. The bench exploits this by changing them mid-symbol.

// File: rtl/fsksq_pkg.sv
package fsksq_pkg;

    localparam int unsigned DEF_DATA_W  = 22;
    localparam int unsigned DEF_TONE_W  = 8;
    localparam int unsigned DEF_PRESC_W = 10;

    typedef enum logic {
        TONE_LO = 1'b0,
        TONE_HI = 1'b1
    } tone_sel_e;

    function automatic tone_sel_e sel_from_bit(input logic b);
        return b ? TONE_HI : TONE_LO;
    endfunction

endpackage

// File: rtl/fsksq_prescaler.sv
module fsksq_prescaler #(
    parameter int unsigned PRESC_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    output logic               tick_o,
    output logic [PRESC_W-1:0] count_o
);
    localparam logic [PRESC_W-1:0] LAST = '1;

    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (!en_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o  = en_i && (cnt_q == LAST);
    assign count_o = cnt_q;
endmodule

// File: rtl/fsksq_pointer.sv
module fsksq_pointer #(
    parameter int unsigned N = 22
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         adv_i,
    output logic [N-1:0] ptr_o,
    output logic         wrap_o
);
    localparam logic [N-1:0] HOME = N'(1);

    logic [N-1:0] ptr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            ptr_q <= HOME;
        else if (!en_i)
            ptr_q <= HOME;
        else if (adv_i)
            ptr_q <= {ptr_q[N-2:0], ptr_q[N-1]};
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = adv_i && ptr_q[N-1];
endmodule

// File: rtl/fsksq_bitsel.sv
module fsksq_bitsel #(
    parameter int unsigned N = 22
) (
    input  logic [N-1:0] ptr_i,
    input  logic [N-1:0] word_i,
    output logic         bit_o
);
    logic [N-1:0] masked;

    for (genvar g = 0; g < N; g++) begin : g_mask
        assign masked[g] = ptr_i[g] & word_i[g];
    end

    assign bit_o = |masked;
endmodule

// File: rtl/fsksq_top.sv
module fsksq_top
    import fsksq_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned TONE_W  = DEF_TONE_W,
    parameter int unsigned PRESC_W = DEF_PRESC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [TONE_W-1:0] tone_hi_i,
    input  logic [TONE_W-1:0] tone_lo_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [TONE_W-1:0] sample_o,
    output logic              frame_o
);
    logic               tick_w;
    logic [PRESC_W-1:0] presc_w;
    logic [DATA_W-1:0]  ptr_w;
    logic               wrap_w;
    logic               bit_w;
    tone_sel_e          sel_w;
    logic [TONE_W-1:0]  sample_q;
    logic               frame_q;

    fsksq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .tick_o  (tick_w),
        .count_o (presc_w)
    );

    fsksq_pointer #(.N(DATA_W)) u_ptr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .adv_i  (tick_w),
        .ptr_o  (ptr_w),
        .wrap_o (wrap_w)
    );

    fsksq_bitsel #(.N(DATA_W)) u_sel (
        .ptr_i  (ptr_w),
        .word_i (word_i),
        .bit_o  (bit_w)
    );

    assign sel_w = sel_from_bit(bit_w);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sample_q <= '0;
            frame_q  <= 1'b0;
        end else if (!en_i) begin
            sample_q <= '0;
            frame_q  <= 1'b0;
        end else begin
            sample_q <= (sel_w == TONE_HI) ? tone_hi_i : tone_lo_i;
            frame_q  <= wrap_w;
        end
    end

    assign sample_o = sample_q;
    assign frame_o  = frame_q;
endmodule

// File: rtl/fsksq_checker.sv
module fsksq_checker #(
    parameter int unsigned DATA_W  = 22,
    parameter int unsigned TONE_W  = 8,
    parameter int unsigned PRESC_W = 10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               en_i,
    input logic [TONE_W-1:0]  tone_hi_i,
    input logic [TONE_W-1:0]  tone_lo_i,
    input logic [TONE_W-1:0]  sample_o,
    input logic               frame_o,
    input logic [DATA_W-1:0]  ptr,
    input logic [PRESC_W-1:0] presc
);
    localparam logic [PRESC_W-1:0] LAST = '1;
    localparam logic [DATA_W-1:0]  HOME = DATA_W'(1);

    p_ptr_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(ptr) == 1);

    p_disabled_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (sample_o == '0 && !frame_o && presc == '0 && ptr == HOME));

    p_ptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && presc != LAST) |=> $stable(ptr));

    p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && presc == LAST && !ptr[DATA_W-1]) |=> (ptr == ($past(ptr) << 1)));

    p_ptr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && presc == LAST && ptr[DATA_W-1]) |=> (ptr == HOME && frame_o));

    p_frame_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |=> !frame_o);

    p_out_tone_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (sample_o == $past(tone_hi_i) || sample_o == $past(tone_lo_i)));
endmodule

bind fsksq_top fsksq_checker #(
    .DATA_W  (DATA_W),
    .TONE_W  (TONE_W),
    .PRESC_W (PRESC_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tone_hi_i (tone_hi_i),
    .tone_lo_i (tone_lo_i),
    .sample_o  (sample_o),
    .frame_o   (frame_o),
    .ptr       (ptr_w),
    .presc     (presc_w)
);

// File: tb/fsksq_top_tb.sv
module fsksq_top_tb;
    localparam int DW  = 22;
    localparam int TW  = 8;
    localparam int SYM = 1024;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [TW-1:0] hi;
    logic [TW-1:0] lo;
    logic [DW-1:0] word;
    logic [TW-1:0] sample;
    logic          frame;

    int n_chk  = 0;
    int n_fail = 0;
    int pos;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsksq_top u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .tone_hi_i (hi),
        .tone_lo_i (lo),
        .word_i    (word),
        .sample_o  (sample),
        .frame_o   (frame)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] tone_for(input int k);
        return word[k] ? hi : lo;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // advance so that state is the one after enabled edge E(m)
    task automatic adv_to(input int m);
        step(m - pos);
        pos = m;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; hi = 8'hC3; lo = 8'h3C; word = 22'h2D5A3D;
        step(3);
        chk("R1 reset sample", 32'(sample), 0);
        chk("R1 reset frame", 32'(frame), 0);
        rst_n = 1'b1;
        step(2);
        chk("R7 idle sample", 32'(sample), 0);
    endtask

    task automatic t_walk();
        en = 1'b1; pos = -1;
        adv_to(0);    chk("R2 first bit", 32'(sample), 32'(tone_for(0)));
        adv_to(1023); chk("R4 end of bit0", 32'(sample), 32'(tone_for(0)));
        chk("R6 no early frame", 32'(frame), 0);
        adv_to(1024); chk("R4 start of bit1", 32'(sample), 32'(tone_for(1)));
        for (int k = 2; k < DW; k++) begin
            adv_to(SYM*k + 512);
            chk("R2 R3 mid bit", 32'(sample), 32'(tone_for(k)));
        end
        adv_to(SYM*DW - 2); chk("R6 frame before wrap", 32'(frame), 0);
        adv_to(SYM*DW - 1); chk("R6 frame pulse", 32'(frame), 1);
        chk("R4 last bit held", 32'(sample), 32'(tone_for(DW-1)));
        adv_to(SYM*DW);     chk("R6 frame one cycle", 32'(frame), 0);
        chk("R5 wrap to bit0", 32'(sample), 32'(tone_for(0)));
        adv_to(SYM*DW + SYM + 100);
        chk("R5 repeat bit1", 32'(sample), 32'(tone_for(1)));
    endtask

    task automatic t_disable_restart();
        en = 1'b0;
        step(1);
        chk("R7 disabled sample", 32'(sample), 0);
        chk("R7 disabled frame", 32'(frame), 0);
        step(5);
        chk("R7 stays zero", 32'(sample), 0);
        en = 1'b1; pos = -1;
        adv_to(0);    chk("R7 restart bit0", 32'(sample), 32'(tone_for(0)));
        adv_to(1023); chk("R7 full first symbol", 32'(sample), 32'(tone_for(0)));
        adv_to(1024); chk("R7 then bit1", 32'(sample), 32'(tone_for(1)));
    endtask

    task automatic t_follow();
        // now in bit1, word[1]=0 so low tone is sent
        lo = 8'h5A;
        step(1); pos++;
        chk("R8 low tone follows", 32'(sample), 32'h5A);
        word = 22'h3FFFFF;
        step(1); pos++;
        chk("R8 R3 data follows", 32'(sample), 32'(hi));
        hi = 8'hE1;
        step(1); pos++;
        chk("R8 high tone follows", 32'(sample), 32'hE1);
        word = 22'h000000;
        step(1); pos++;
        chk("R3 zero word low tone", 32'(sample), 32'h5A);
        word = 22'h2D5A3D;
    endtask

    task automatic t_async_reset();
        #1 rst_n = 1'b0;
        #0.5;
        chk("R1 async clear sample", 32'(sample), 0);
        chk("R1 async clear frame", 32'(frame), 0);
        @(negedge clk);
        rst_n = 1'b1; pos = -1;
        adv_to(0);    chk("R1 after reset bit0", 32'(sample), 32'(tone_for(0)));
        adv_to(1023); chk("R1 bit0 full length", 32'(sample), 32'(tone_for(0)));
        adv_to(1024); chk("R1 then bit1", 32'(sample), 32'(tone_for(1)));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_walk();
        t_disable_restart();
        t_follow();
        t_async_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule